// File: doc/BRIEF.md
# Serial Sampling-Converter Readout Controller

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. When `start_i` is seen while idle, it pulls the active-low select low and then toggles a data clock made by dividing the system clock. It counts the rising edges of that clock. The rising edges that fall in the converter's input sampling window are skipped. The low marker bit is checked, and the data bits are then shifted in most significant bit first. The converter updates its data line on the falling clock edge, so the controller samples it on the rising edge.

The frame can be cut short after a programmable number of data bits, which gives a coarse result at lower power. When a full word is requested, a check mode keeps the clock running through the converter's repeat of the word in reverse bit order and compares every repeated bit with the captured one. At the end of a frame, select goes high again and a single-cycle done pulse is raised. The result word and the error flag are updated at that same moment and hold until the next frame ends. Select then stays high for one more half-period before the next start is accepted.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `cs_no`=1, `sclk_o`=0, `done_o`=0, `err_o`=0, `busy_o`=0 and `result_o`=0.
- R2: A start accepted while idle drives `cs_no` low one cycle later with `sclk_o` low. The first rising edge of `sclk_o` follows `div_i`+1 cycles after the accepting edge.
- R3: Each high phase and each low phase of `sclk_o` lasts `div_i`+1 system clocks. `div_i`, `nbits_i` and `verify_i` are latched when a start is accepted.
- R4: The number of bits kept is n = `nbits_i`, except that a value of 0 or above 16 means n = 16.
- R5: A frame has 6+n rising clock edges. In check mode with n = 16 it has 37 instead.
- R6: Rising edges 1 to 5 fall in the sampling window and are ignored. Rising edge 6 samples the marker bit. If that bit is 1, `err_o` is set.
- R7: Rising edge 6+k samples result bit 16-k, for k = 1..n. Result bits not sampled read 0.
- R8: In check mode with n = 16, rising edges 23 to 37 sample bits 1 to 15 again, in that order. Any difference from the captured bit sets `err_o`. With n < 16, check mode has no effect.
- R9: `done_o` is a one-cycle pulse. It is seen 2·L·(`div_i`+1) cycles after the accepting edge, where L is the rising-edge count of R5. In that cycle `cs_no` rises and `sclk_o` is low. `result_o` and `err_o` change only together with `done_o`.
- R10: A start during a frame is ignored, and so are any changes to the settings. The frame in progress keeps its timing and its result.
- R11: After `done_o`, `busy_o` stays high and `cs_no` stays high for `div_i`+1 more cycles. Only then is a new start accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion frame |
| div_i | input | DIV_W | Clock half-period, in system clocks, minus one |
| nbits_i | input | NB_W | Number of data bits to read (0 or >DATA_W means all) |
| verify_i | input | 1 | Enable the reverse-order repeat check on full reads |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Data clock to the converter |
| busy_o | output | 1 | Frame or trailing select-high gap in progress |
| result_o | output | DATA_W | Last captured word, left-aligned |
| done_o | output | 1 | One-cycle frame-complete pulse |
| err_o | output | 1 | Marker or repeat error of the last frame |

## Verification
Every result has a fixed cycle count measured from the edge that accepts the start. `cs_no` falls one edge later. The first clock rise comes `div_i`+1 edges later. `done_o`, the result and the error flag appear after 2·L·(`div_i`+1) edges, and `busy_o` falls `div_i`+1 edges after that. The bench counts system-clock edges from the start, samples 1 ns after each edge, and also checks the cycle just before `done_o` to confirm the pulse is neither early nor late. A behavioural converter model driven by the data clock supplies the bits. It can corrupt the marker bit or one repeated bit, so the cases that must be ignored and the cases that must be flagged can both be observed at `err_o`.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN, ST_GAP} st_e;
endpackage

// File: rtl/sar_rd_tick.sv
module sar_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == div_i) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int DIV_W       = 8,
  parameter int NB_W        = 5,
  parameter int RC_W        = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic             verify_i,
  input  logic             tick_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic             busy_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             done_o,
  output logic             begin_o,
  output logic             rise_o,
  output logic [RC_W-1:0]  rise_num_o,
  output logic             fin_o,
  output logic             chk_o
);
  localparam int NULL_RISE = SAMPLE_CLKS + 1;
  localparam logic [RC_W-1:0] NULL_R = RC_W'(NULL_RISE);
  localparam logic [RC_W-1:0] ALL_R  = RC_W'(NULL_RISE + 2*DATA_W - 1);

  st_e             state_q;
  logic [RC_W-1:0] rc_q, last_rise;
  logic [NB_W-1:0] n_q, n_eff;
  logic            chk_q;

  assign n_eff = (nbits_i == '0 || nbits_i > NB_W'(DATA_W)) ? NB_W'(DATA_W) : nbits_i;
  assign last_rise = chk_q ? ALL_R : NULL_R + RC_W'(n_q);

  assign begin_o    = (state_q == ST_IDLE) && start_i;
  assign rise_o     = tick_i && ((state_q == ST_SETUP) || (state_q == ST_RUN && !sclk_o));
  assign rise_num_o = rc_q + 1'b1;
  assign fin_o      = tick_i && (state_q == ST_RUN) && sclk_o && (rc_q == last_rise);
  assign busy_o     = (state_q != ST_IDLE);
  assign chk_o      = chk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_no   <= 1'b1;
      sclk_o  <= 1'b0;
      done_o  <= 1'b0;
      rc_q    <= '0;
      n_q     <= NB_W'(DATA_W);
      chk_q   <= 1'b0;
      div_q_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          cs_no   <= 1'b0;
          rc_q    <= '0;
          n_q     <= n_eff;
          chk_q   <= verify_i && (n_eff == NB_W'(DATA_W));
          div_q_o <= div_i;
        end
        ST_SETUP: if (tick_i) begin
          state_q <= ST_RUN;
          sclk_o  <= 1'b1;
          rc_q    <= rise_num_o;
        end
        ST_RUN: if (tick_i) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;
            if (rc_q == last_rise) begin
              cs_no   <= 1'b1;
              done_o  <= 1'b1;
              state_q <= ST_GAP;
            end
          end else begin
            sclk_o <= 1'b1;
            rc_q   <= rise_num_o;
          end
        end
        ST_GAP: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  cs_rise_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> ($stable(div_q_o) && $stable(n_q) && $stable(chk_q)));
  // R5
  rise_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (rc_q <= last_rise));
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int RC_W        = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic              rise_i,
  input  logic [RC_W-1:0]   rise_num_i,
  input  logic              chk_i,
  input  logic              fin_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] result_o,
  output logic              err_o
);
  localparam int IW = $clog2(DATA_W);
  localparam logic [RC_W-1:0] NULL_R  = RC_W'(SAMPLE_CLKS + 1);
  localparam logic [RC_W-1:0] FIRST_R = RC_W'(SAMPLE_CLKS + 2);
  localparam logic [RC_W-1:0] LAST_R  = RC_W'(SAMPLE_CLKS + 1 + DATA_W);

  logic [DATA_W-1:0] data_q;
  logic              err_q, is_null, in_data, in_rep;
  logic [RC_W-1:0]   data_off, rep_off;
  logic [IW-1:0]     data_idx, rep_idx;

  always_comb begin
    is_null  = rise_i && (rise_num_i == NULL_R);
    in_data  = rise_i && (rise_num_i >= FIRST_R) && (rise_num_i <= LAST_R);
    in_rep   = rise_i && chk_i && (rise_num_i > LAST_R);
    data_off = LAST_R - rise_num_i;
    rep_off  = rise_num_i - LAST_R;
    data_idx = data_off[IW-1:0];
    rep_idx  = rep_off[IW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      err_q    <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      if (begin_i) begin
        data_q <= '0;
        err_q  <= 1'b0;
      end else begin
        if (in_data) data_q[data_idx] <= sdo_i;
        if (is_null && sdo_i) err_q <= 1'b1;
        if (in_rep && (sdo_i != data_q[rep_idx])) err_q <= 1'b1;
      end
      if (fin_i) begin
        result_o <= data_q;
        err_o    <= err_q;
      end
    end
  end

  // R6
  null_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_null && sdo_i) |=> err_q);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin_i |=> ($stable(result_o) && $stable(err_o)));
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl #(
  parameter int DATA_W      = 16,
  parameter int SAMPLE_CLKS = 5,
  parameter int DIV_W       = 8,
  parameter int NB_W        = $clog2(DATA_W + 1),
  localparam int RC_W       = $clog2(SAMPLE_CLKS + 2*DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              verify_i,
  input  logic              sdo_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              err_o
);
  logic [DIV_W-1:0] div_q;
  logic             tick, begin_ev, rise_ev, fin_ev, chk;
  logic [RC_W-1:0]  rise_num;

  sar_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(busy_o), .div_i(div_q), .tick_o(tick)
  );

  sar_rd_seq #(
    .DATA_W(DATA_W), .SAMPLE_CLKS(SAMPLE_CLKS), .DIV_W(DIV_W), .NB_W(NB_W), .RC_W(RC_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .div_i, .nbits_i, .verify_i,
    .tick_i(tick), .div_q_o(div_q), .busy_o, .cs_no, .sclk_o, .done_o,
    .begin_o(begin_ev), .rise_o(rise_ev), .rise_num_o(rise_num), .fin_o(fin_ev), .chk_o(chk)
  );

  sar_rd_capture #(
    .DATA_W(DATA_W), .SAMPLE_CLKS(SAMPLE_CLKS), .RC_W(RC_W)
  ) u_cap (
    .clk_i, .rst_ni, .begin_i(begin_ev), .rise_i(rise_ev), .rise_num_i(rise_num),
    .chk_i(chk), .fin_i(fin_ev), .sdo_i, .result_o, .err_o
  );

  // R2
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R11
  gap_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> cs_no);
endmodule

// File: tb/tb_sar_readout_ctrl.sv
`timescale 1ns/1ps
module tb_sar_readout_ctrl;
  logic        clk_i = 0, rst_ni = 0, start_i = 0, verify_i = 0, sdo_i = 1;
  logic [7:0]  div_i = 0;
  logic [4:0]  nbits_i = 0;
  logic        cs_no, sclk_o, busy_o, done_o, err_o;
  logic [15:0] result_o;
  int checks = 0, errors = 0;

  logic [15:0] m_word;
  bit          m_bad_null;
  int          m_bad_pos;
  int          fc, rises;

  always #2.5 clk_i = ~clk_i;

  sar_readout_ctrl dut (
    .clk_i, .rst_ni, .start_i, .div_i, .nbits_i, .verify_i, .sdo_i,
    .cs_no, .sclk_o, .busy_o, .result_o, .done_o, .err_o
  );

  // converter model: data changes on the falling clock edge
  always @(negedge sclk_o or posedge cs_no) begin
    if (cs_no) begin
      fc = 0; sdo_i = 1'b1;
    end else begin
      fc = fc + 1;
      if (fc == 5)                   sdo_i = m_bad_null;
      else if (fc >= 6 && fc <= 21)  sdo_i = m_word[21 - fc];
      else if (fc >= 22 && fc <= 36) sdo_i = m_word[fc - 21] ^ ((fc - 21) == m_bad_pos);
      else                           sdo_i = 1'b1;
    end
  end

  always @(posedge sclk_o or negedge cs_no) begin
    if (!cs_no && sclk_o) rises = rises + 1;
    else if (!cs_no) rises = 0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic frame(input int dv, input int nb, input bit ver, input logic [15:0] w,
                       input bit bad_null, input int bad_pos, input bit poke);
    int n, L, M, g;
    logic [15:0] mask, exp_res;
    bit exp_err;
    n = (nb == 0 || nb > 16) ? 16 : nb;
    L = (ver && n == 16) ? 37 : 6 + n;
    M = 2 * L * (dv + 1);
    mask = (n == 16) ? 16'hFFFF : 16'(~((32'd1 << (16 - n)) - 1));
    exp_res = w & mask;
    exp_err = bad_null || (ver && n == 16 && bad_pos != 0);
    m_word = w; m_bad_null = bad_null; m_bad_pos = bad_pos;
    @(negedge clk_i);
    div_i = 8'(dv); nbits_i = 5'(nb); verify_i = ver; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk(cs_no == 0 && sclk_o == 0, "R2 select low", {cs_no, sclk_o}, 0);
    for (int c = 1; c <= M; c++) begin
      @(posedge clk_i); #1;
      if (c == dv) chk(sclk_o == 0, "R2 no early rise", sclk_o, 0);
      if (c == dv + 1) chk(sclk_o == 1, "R2/R3 first rise", sclk_o, 1);
      if (c == 3 * (dv + 1)) chk(sclk_o == 1, "R3 second rise", sclk_o, 1);
      if (poke && c == dv + 3) begin start_i = 1; div_i = 8'd5; nbits_i = 5'd2; verify_i = ~ver; end
      if (poke && c == dv + 4) start_i = 0;
      if (c == M - 1) chk(done_o == 0, "R9 not early", done_o, 0);
    end
    chk(done_o == 1, "R9 done timing", done_o, 1);
    chk(cs_no == 1 && sclk_o == 0, "R9 select high at done", {cs_no, sclk_o}, 2'b10);
    chk(rises == L, "R5 rise count", rises, L);
    chk(result_o == exp_res, "R7 result", result_o, exp_res);
    chk(err_o == exp_err, "R6/R8 error flag", err_o, exp_err);
    g = 0;
    while (busy_o && g < 1000) begin
      @(posedge clk_i); #1; g++;
      if (g == 1) chk(done_o == 0, "R9 one-cycle pulse", done_o, 0);
    end
    chk(g == dv + 1 && cs_no == 1, "R11 gap length", g, dv + 1);
    chk(result_o == exp_res, "R9 result held", result_o, exp_res);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_word = 0; m_bad_null = 0; m_bad_pos = 0; fc = 0; rises = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(cs_no == 1 && sclk_o == 0 && done_o == 0 && err_o == 0 && busy_o == 0 && result_o == 0,
        "R1 reset state", {cs_no, sclk_o, done_o, err_o, busy_o}, 5'b10000);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    chk(cs_no == 1 && busy_o == 0 && result_o == 0, "R1 after release", {cs_no, busy_o}, 2'b10);
    // sweep: divider, bit count (incl. R4 encodings 0, 17, 31), check mode
    for (int dv = 0; dv < 3; dv++)
      for (int nb = 0; nb <= 18; nb++)
        for (int ver = 0; ver < 2; ver++) begin
          int nbv;
          nbv = (nb == 18) ? 31 : nb;
          frame(dv, nbv, ver[0], 16'(32'hB3C5 ^ (nbv * 32'h0F0F) ^ (dv * 32'h1357)), 0, 0, 0);
        end
    // boundary words
    frame(1, 16, 1, 16'h0000, 0, 0, 0);
    frame(1, 16, 1, 16'hFFFF, 0, 0, 0);
    frame(0, 16, 0, 16'h8000, 0, 0, 0);
    frame(0, 16, 1, 16'h7FFF, 0, 0, 0);
    frame(2, 3, 0, 16'hE000, 0, 0, 0);
    // R6 marker bit high
    frame(0, 16, 0, 16'h1234, 1, 0, 0);
    frame(1, 3, 1, 16'h1234, 1, 0, 0);
    // R8 repeat corruption, first and last repeated bit
    frame(0, 16, 1, 16'hA5C3, 0, 1, 0);
    frame(1, 0, 1, 16'hA5C3, 0, 15, 0);
    // R8 check mode ignored when short or disabled
    frame(0, 12, 1, 16'hA5C3, 0, 7, 0);
    frame(0, 16, 0, 16'hA5C3, 0, 7, 0);
    // error cleared by the next clean frame
    frame(0, 16, 1, 16'h5A3C, 0, 0, 0);
    // R10 start and setting changes during a frame
    frame(1, 16, 1, 16'hC0DE, 0, 0, 1);
    frame(2, 5, 0, 16'hBEEF, 0, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule